// File: doc/BRIEF.md
# Fast Strip Cluster Finder

This block produces prompt trigger seeds from a strip detector front end. A crossing tick marks each beam crossing, and on that tick the block takes the full strip hit pattern. The pattern is split into independent banks of 128 strips. Each bank has a single capture register. The block runs on a fast clock with four cycles per crossing. Over several of those cycles, each bank walks its captured pattern one segment at a time. It keeps a saturating hit count and the lowest and highest hit addresses it has seen.

Only a strictly isolated cluster is accepted. That means one hit strip, or two neighbouring hit strips, and no other hit anywhere in the bank. The result is a fixed nine-bit word. Each bank sends its word on its own serial line, at a fixed latency of four crossings after the event.

A bank stays occupied from its capture until the last bit of its word has left. Crossing ticks that arrive in that time are ignored by that bank. Each bank has its own enable, which gates whether the bank captures at a tick.

Top module: `fast_cluster_finder`

## Requirements
- R1: After synchronous reset every serial output is 0, and every bank is idle, so the first enabled tick after reset is captured.
- R2: On a clock edge where `bc_tick` is 1, an idle bank whose enable is 1 captures its strips. Bank b owns `strips[b*128 +: 128]`, and strip address a within that bank is bit a of its slice.
- R3: If a bank holds exactly one hit at address a, its word has valid=1, address=a and width=0. This includes a=0 and a=127.
- R4: If a bank holds exactly two hits at addresses a and a+1, its word has valid=1, address=a and width=1. This also holds when a and a+1 fall in different 32-strip scan segments.
- R5: If a bank holds no hit, more than two hits, or two hits that are not neighbours, its word is all zeros.
- R6: The word is 9 bits and is sent most significant bit first: bit 8 is valid, bits 7:1 are the address (MSB first), and bit 0 is the width flag. Outside a word the line is 0.
- R7: If a capture happens at clock edge n, word bit 8−k is on the bank's line after edge n+16+k, for k = 0 to 8. Edge n+16 is the fourth crossing tick after the event.
- R8: A bank that captured at edge n ignores every tick up to and including edge n+25. It accepts a tick at edge n+28.
- R9: A bank whose enable is 0 at a tick does not capture, and its line stays 0 for that event.
- R10: Banks work independently. Each bank's word depends only on its own 128 strips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per beam crossing |
| rst | input | 1 | Synchronous active-high reset |
| bc_tick | input | 1 | One-cycle pulse sampled at the crossing edge |
| bank_en | input | N_BANKS | Per-bank capture enable |
| strips | input | N_BANKS*BANK_STRIPS | Strip hit pattern, bank b in slice b*BANK_STRIPS |
| cluster_ser | output | N_BANKS | Serial cluster word, one line per bank |

## Verification
The bench uses the default parameters: two banks of 128 strips, 32-strip scan segments, four fast cycles per crossing and a latency of four crossings. With these values each bank scans in four steps. A neighbouring pair at strips 31 and 32 therefore tests how results are merged across segments, and a split pair at 63 and 65 tests rejection across a boundary. With a 25-cycle busy window, a burst of back-to-back ticks shows six ignored events followed by an accepted one. The latency check lands exactly on the fourth later tick.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    // Hit count saturates at 3: anything above two hits is rejected anyway.
    typedef logic [1:0] hitcnt_t;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_BUSY = 1'b1
    } bank_state_e;

    function automatic hitcnt_t sat_add(input hitcnt_t a, input hitcnt_t b);
        logic [2:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return (sum > 3'd3) ? 2'd3 : sum[1:0];
    endfunction

endpackage

// File: rtl/fcf_seg_scan.sv
module fcf_seg_scan
    import fcf_pkg::*;
#(
    parameter int SEG_W = 32,
    localparam int IDX_W = $clog2(SEG_W)
) (
    input  logic [SEG_W-1:0] seg,
    output hitcnt_t          cnt,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] last_idx
);

    always_comb begin
        cnt       = '0;
        first_idx = '0;
        last_idx  = '0;
        for (int i = 0; i < SEG_W; i++) begin
            cnt = sat_add(cnt, {1'b0, seg[i]});
            if (seg[i]) last_idx = IDX_W'(i);
        end
        for (int i = SEG_W - 1; i >= 0; i--) begin
            if (seg[i]) first_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fcf_bank.sv
module fcf_bank
    import fcf_pkg::*;
#(
    parameter int BANK_STRIPS = 128,
    parameter int SEG_W       = 32,
    parameter int FAST_PER_BC = 4,
    parameter int LAT_BC      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   en,
    input  logic [BANK_STRIPS-1:0] strips,
    output logic                   ser
);

    localparam int ADDR_W = $clog2(BANK_STRIPS);
    localparam int IDX_W  = $clog2(SEG_W);
    localparam int NSEG   = BANK_STRIPS / SEG_W;
    localparam int WORD_W = ADDR_W + 2;
    localparam int TX0    = LAT_BC * FAST_PER_BC;
    localparam int LAST   = TX0 + WORD_W - 1;
    localparam int CNT_W  = $clog2(LAST + 1);
    localparam logic [CNT_W-1:0] TX_LOAD = CNT_W'(TX0 - 1);
    localparam logic [CNT_W-1:0] TX_END  = CNT_W'(LAST);

    bank_state_e             state;
    logic [CNT_W-1:0]        cnt;
    logic [BANK_STRIPS-1:0]  cap;
    hitcnt_t                 acc_cnt;
    logic [ADDR_W-1:0]       acc_first, acc_last;
    logic [WORD_W-1:0]       shreg;
    logic                    tx;

    // Segment selection for the current scan step
    logic [SEG_W-1:0]  seg;
    logic              scanning;
    logic [ADDR_W-1:0] seg_base;

    always_comb begin
        seg = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (cnt == CNT_W'(s)) seg = cap[s*SEG_W +: SEG_W];
        end
    end

    assign scanning = (state == BANK_BUSY) && (cnt < CNT_W'(NSEG));
    assign seg_base = ADDR_W'(32'(cnt) * SEG_W);

    hitcnt_t          seg_cnt;
    logic [IDX_W-1:0] seg_first, seg_last;

    fcf_seg_scan #(.SEG_W(SEG_W)) u_scan (
        .seg       (seg),
        .cnt       (seg_cnt),
        .first_idx (seg_first),
        .last_idx  (seg_last)
    );

    // Acceptance: one strip, or two neighbours and nothing else
    logic              accept;
    logic [WORD_W-1:0] word;

    always_comb begin
        accept = (acc_cnt == 2'd1) ||
                 ((acc_cnt == 2'd2) && (acc_last == acc_first + ADDR_W'(1)));
        word   = accept ? {1'b1, acc_first, (acc_cnt == 2'd2)} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BANK_IDLE;
            cnt       <= '0;
            cap       <= '0;
            acc_cnt   <= '0;
            acc_first <= '0;
            acc_last  <= '0;
            shreg     <= '0;
            tx        <= 1'b0;
        end else begin
            case (state)
                BANK_IDLE: begin
                    if (tick && en) begin
                        cap       <= strips;
                        state     <= BANK_BUSY;
                        cnt       <= '0;
                        acc_cnt   <= '0;
                        acc_first <= '0;
                        acc_last  <= '0;
                    end
                end
                BANK_BUSY: begin
                    cnt <= cnt + CNT_W'(1);
                    if (scanning && (seg_cnt != 2'd0)) begin
                        acc_cnt  <= sat_add(acc_cnt, seg_cnt);
                        acc_last <= seg_base + ADDR_W'(seg_last);
                        if (acc_cnt == 2'd0) acc_first <= seg_base + ADDR_W'(seg_first);
                    end
                    if (cnt == TX_LOAD) begin
                        shreg <= word;
                        tx    <= 1'b1;
                    end else if (tx) begin
                        shreg <= shreg << 1;
                    end
                    if (cnt == TX_END) begin
                        state <= BANK_IDLE;
                        tx    <= 1'b0;
                        cnt   <= '0;
                    end
                end
                default: state <= BANK_IDLE;
            endcase
        end
    end

    assign ser = tx & shreg[WORD_W-1];

    AST_IDLE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (state == BANK_IDLE && !(tick && en)) |=> (state == BANK_IDLE)); // R9
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == BANK_BUSY) |=> $stable(cap)); // R8
    AST_TX_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        (state == BANK_BUSY && cnt == TX_LOAD) |=> tx); // R7
    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx) && !shreg[WORD_W-1]) |-> (shreg == '0)); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == BANK_IDLE) |-> !ser); // R6

endmodule

// File: rtl/fast_cluster_finder.sv
module fast_cluster_finder
    import fcf_pkg::*;
#(
    parameter int N_BANKS     = 2,
    parameter int BANK_STRIPS = 128,
    parameter int SEG_W       = 32,
    parameter int FAST_PER_BC = 4,
    parameter int LAT_BC      = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bc_tick,
    input  logic [N_BANKS-1:0]             bank_en,
    input  logic [N_BANKS*BANK_STRIPS-1:0] strips,
    output logic [N_BANKS-1:0]             cluster_ser
);

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        fcf_bank #(
            .BANK_STRIPS (BANK_STRIPS),
            .SEG_W       (SEG_W),
            .FAST_PER_BC (FAST_PER_BC),
            .LAT_BC      (LAT_BC)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .tick   (bc_tick),
            .en     (bank_en[b]),
            .strips (strips[b*BANK_STRIPS +: BANK_STRIPS]),
            .ser    (cluster_ser[b])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (cluster_ser == '0)); // R1

endmodule

// File: tb/sim_fast_cluster_finder.sv
module sim_fast_cluster_finder;

    localparam int NB    = 2;
    localparam int BS    = 128;
    localparam int WW    = 9;
    localparam int LATC  = 16;
    localparam int BUSYC = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic             bc_tick;
    logic [NB-1:0]    bank_en = '0;
    logic [NB*BS-1:0] strips  = '0;
    logic [NB-1:0]    ser;

    assign bc_tick = !rst && ((cyc % 4) == 3);

    fast_cluster_finder u0 (
        .clk         (clk),
        .rst         (rst),
        .bc_tick     (bc_tick),
        .bank_en     (bank_en),
        .strips      (strips),
        .cluster_ser (ser)
    );

    typedef struct {
        int            start;
        logic [WW-1:0] word;
        string         tag;
    } exp_t;

    exp_t          exp_q[NB][$];
    int            free_at[NB];
    logic [WW-1:0] got[NB];
    int            checks = 0;
    int            errors = 0;

    task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                         input logic [WW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, expv, cyc);
        end
    endtask

    function automatic logic [WW-1:0] model(input logic [BS-1:0] h);
        int n = 0;
        int lo = 0;
        int hi = 0;
        for (int i = BS - 1; i >= 0; i--) if (h[i]) lo = i;
        for (int i = 0; i < BS; i++) if (h[i]) begin n++; hi = i; end
        if (n == 1) return {1'b1, 7'(lo), 1'b0};
        if (n == 2 && hi == lo + 1) return {1'b1, 7'(lo), 1'b1};
        return '0;
    endfunction

    task automatic send(input logic [NB*BS-1:0] h, input logic [NB-1:0] en, input string tag);
        int n;
        exp_t e;
        do @(negedge clk); while (!bc_tick);
        strips  = h;
        bank_en = en;
        n = cyc + 1;
        for (int b = 0; b < NB; b++) begin
            if (en[b] && n >= free_at[b]) begin
                e.start = n + LATC;
                e.word  = model(h[b*BS +: BS]);
                e.tag   = tag;
                exp_q[b].push_back(e);
                free_at[b] = n + BUSYC;
            end
        end
        @(negedge clk);
        strips  = '0;
        bank_en = '0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Monitor: compares the serial lines against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            for (int b = 0; b < NB; b++) begin
                if (exp_q[b].size() != 0 && cyc >= exp_q[b][0].start) begin
                    int k;
                    k = cyc - exp_q[b][0].start;
                    got[b] = {got[b][WW-2:0], ser[b]};
                    if (k == WW - 1) begin
                        check(got[b] == exp_q[b][0].word, exp_q[b][0].tag, got[b], exp_q[b][0].word);
                        void'(exp_q[b].pop_front());
                    end
                end else if (ser[b]) begin
                    check(1'b0, "R8 or R9 (unexpected bit)", WW'(ser[b]), '0);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            check(1'b0, "R7 watchdog", '0, '1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NB*BS-1:0] h;
        for (int b = 0; b < NB; b++) free_at[b] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ser == '0, "R1 reset outputs", WW'(ser), '0);

        // R3 R10 R2: single hits, one per bank
        h = '0; h[5] = 1'b1; h[BS + 72] = 1'b1;
        send(h, 2'b11, "R3 single hit");
        idle(30);

        // R4: neighbouring pair across a segment boundary, and at the top of bank 1
        h = '0; h[31] = 1'b1; h[32] = 1'b1; h[BS + 126] = 1'b1; h[BS + 127] = 1'b1;
        send(h, 2'b11, "R4 adjacent pair");
        idle(30);

        // R5: split pair and a triple
        h = '0; h[10] = 1'b1; h[12] = 1'b1; h[BS + 40] = 1'b1; h[BS + 41] = 1'b1; h[BS + 42] = 1'b1;
        send(h, 2'b11, "R5 rejected pattern");
        idle(30);

        // R3 boundary address 0, and R5 empty bank
        h = '0; h[0] = 1'b1;
        send(h, 2'b11, "R3 address 0 / R5 empty");
        idle(30);

        // R3 boundary address 127 and bank 1 address 0 (R2 mapping)
        h = '0; h[127] = 1'b1; h[BS] = 1'b1;
        send(h, 2'b11, "R3 address 127 / R2 mapping");
        idle(30);

        // R8: back-to-back ticks; six are ignored and the seventh later one is accepted
        h = '0; h[50] = 1'b1; h[BS + 20] = 1'b1; h[BS + 21] = 1'b1;
        send(h, 2'b11, "R8 first event R7 latency");
        for (int i = 0; i < 7; i++) begin
            h = '0; h[60 + i] = 1'b1; h[BS + 90] = 1'b1;
            send(h, 2'b11, "R8 busy window");
        end
        idle(30);

        // R9: bank 0 disabled, then bank 1 disabled
        h = '0; h[9] = 1'b1; h[BS + 9] = 1'b1;
        send(h, 2'b10, "R9 bank0 disabled");
        idle(30);
        h = '0; h[77] = 1'b1; h[BS + 3] = 1'b1;
        send(h, 2'b01, "R9 bank1 disabled");
        idle(30);

        // R4 inside a segment, R5 split pair across a boundary, R6 format
        h = '0; h[100] = 1'b1; h[101] = 1'b1; h[BS + 63] = 1'b1; h[BS + 65] = 1'b1;
        send(h, 2'b11, "R6 R4 mid-segment / R5 split");
        idle(40);

        for (int b = 0; b < NB; b++)
            check(exp_q[b].size() == 0, "R7 all words delivered", WW'(exp_q[b].size()), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule